// File: doc/BRIEF.md
# Posted-Write Byte-Lane SRAM Core

This block is a synchronous on-chip memory whose word is split into byte lanes, each with its own write enable. By default the word has two 9-bit lanes (18 bits) and the array holds 64 words. Each cycle the block takes at most one command: a read or a write, with an address. A write also carries a data word and one enable bit per lane.

A write does not go into the array when it arrives. Its address, data and lane enables are parked in a holding register. The array write of that parked entry happens only when the next write command arrives. In that same cycle the new write replaces it in the holding register. Because of this, a read never has to share the array with a pending write.

Reads look at the holding register first. For a read to the parked address, each lane that was enabled in the parked write is taken from the register. Every other lane comes from the array. So a read always returns the newest data, one clock after the command.

Top module: `posted_sram`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `rvalid` is low. After reset the holding register is invalid, so the first write commits nothing to the array.
- R2: A read command (`cmd_valid`=1, `cmd_write`=0) raises `rvalid` on the next clock, with `rdata` for that read. `rvalid` is low in every cycle that does not follow a read command.
- R3: A read to the address written by the immediately preceding write returns the data of that write in every lane it enabled. Lane 0 is `wdata[8:0]`, enabled by `wbe[0]`. Lane 1 is `wdata[17:9]`, enabled by `wbe[1]`.
- R4: A lane whose `wbe` bit is 0 during a write keeps its stored contents. This holds both while the write is parked and after it has been committed to the array.
- R5: A parked write stays pending across any number of reads. It is written to the array by the next write command, and afterwards a read of its address returns its data from the array.
- R6: Read forwarding merges per lane. For a read to the parked address, lanes enabled in the parked write come from the holding register, and the remaining lanes come from the array.
- R7: When a write arrives while another write is parked, the parked entry is committed first and the new write is parked in the same cycle. This also works when both writes target the same address with different lane enables.
- R8: A write with both lane enables at 0 still commits any parked entry. It changes no stored lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read (when `cmd_valid` is 1) |
| addr | input | ADDR_W (6) | Word address |
| wdata | input | LANE_W*LANES (18) | Write data, lane i at bits [i*9 +: 9] |
| wbe | input | LANES (2) | Per-lane write enable |
| rdata | output | LANE_W*LANES (18) | Read data, valid when `rvalid` is 1 |
| rvalid | output | 1 | Read data valid, one clock after a read command |

## Verification
The bench checks every read against a reference array that applies each write at once, so a late or missing commit shows up as stale data.

- Reads that follow a write to the same address catch a design that skips the holding register. Such a design returns the old array word.
- A read after a partial-lane write, then another read after the next write has committed it, catches a design that writes the disabled lane or forwards the whole word. Either fault shows up as a corrupted lane.
- Several reads between two writes, then a read after the commit, expose a design that loses or commits the parked entry too early.
- Two writes in a row to one address, and a write with no lanes enabled, expose a design that captures before committing or drops the commit.

// File: rtl/posted_sram.sv
module posted_sram #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic                     cmd_write,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LANE_W*LANES-1:0]  wdata,
  input  logic [LANES-1:0]         wbe,
  output logic [LANE_W*LANES-1:0]  rdata,
  output logic                     rvalid
);
  localparam int DATA_W = LANE_W * LANES;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic              hold_vld;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;
  logic [LANES-1:0]  hold_be;

  logic              do_wr, do_rd, hit;
  logic [DATA_W-1:0] arr_word, merged;

  assign do_wr    = cmd_valid & cmd_write;
  assign do_rd    = cmd_valid & ~cmd_write;
  assign hit      = hold_vld && (hold_addr == addr);
  assign arr_word = mem[addr];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] = (hit && hold_be[g]) ?
      hold_data[g*LANE_W +: LANE_W] : arr_word[g*LANE_W +: LANE_W];

    assert_fwd_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (do_rd && hold_vld && hold_addr == addr && hold_be[g]) |=>
        rdata[g*LANE_W +: LANE_W] == $past(hold_data[g*LANE_W +: LANE_W]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld  <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
      hold_be   <= '0;
    end else if (do_wr) begin
      hold_vld  <= 1'b1;
      hold_addr <= addr;
      hold_data <= wdata;
      hold_be   <= wbe;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr && hold_vld) begin
      for (int i = 0; i < LANES; i++) begin
        if (hold_be[i]) mem[hold_addr][i*LANE_W +: LANE_W] <= hold_data[i*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= do_rd;
      if (do_rd) rdata <= merged;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |=> !rvalid);

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    do_rd |=> rvalid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !do_rd |=> !rvalid);

  assert_park_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    do_wr |=> (hold_vld && hold_addr == $past(addr) && hold_be == $past(wbe)));

  assert_park_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !do_wr |=> ($stable(hold_vld) && $stable(hold_addr) && $stable(hold_data) && $stable(hold_be)));
endmodule

// File: tb/posted_sram_tb.sv
`timescale 1ns/1ps
module posted_sram_tb;
  localparam int AW = 6;
  localparam int LW = 9;
  localparam int NL = 2;
  localparam int DW = LW * NL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [NL-1:0] wbe = '0;
  logic [DW-1:0] rdata;
  logic rvalid;

  int total = 0, bad = 0;
  logic [DW-1:0] ref_mem [1<<AW];
  logic [DW-1:0] exp_q [$];
  string tag_q [$];
  logic prev_rd = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;

  posted_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .addr(addr), .wdata(wdata), .wbe(wbe), .rdata(rdata), .rvalid(rvalid));

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NL-1:0] be);
    @(posedge clk); #1;
    cmd_valid = 1; cmd_write = 1; addr = a; wdata = d; wbe = be;
    for (int i = 0; i < NL; i++)
      if (be[i]) ref_mem[a][i*LW +: LW] = d[i*LW +: LW];
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string req);
    @(posedge clk); #1;
    cmd_valid = 1; cmd_write = 0; addr = a; wdata = '0; wbe = '0;
    exp_q.push_back(ref_mem[a]);
    tag_q.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      cmd_valid = 0; cmd_write = 0;
    end
  endtask

  always @(posedge clk) prev_rd <= rst_n && cmd_valid && !cmd_write;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rvalid !== prev_rd) check("R2 rvalid timing", {{(DW-1){1'b0}}, rvalid}, {{(DW-1){1'b0}}, prev_rd});
      if (rvalid === 1'b1) begin
        if (exp_q.size() == 0) check("R2 unexpected read data", rdata, '0);
        else check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rvalid in reset", {{(DW-1){1'b0}}, rvalid}, '0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    check("R1 rvalid after reset", {{(DW-1){1'b0}}, rvalid}, '0);

    for (int a = 0; a < (1 << AW); a++) do_write(a[AW-1:0], DW'(a * 1234 + 7), 2'b11);
    do_read(63, "R3 forward after fill");
    do_read(0, "R5 committed fill word");
    do_read(62, "R5 committed fill word");

    do_write(5, 18'h2_ABCD, 2'b11);
    do_read(5, "R3 forward full word");
    do_write(5, 18'h1_5555, 2'b01);
    do_read(5, "R4 masked lane while parked");
    do_write(9, 18'h0_1111, 2'b11);
    do_read(5, "R4 masked lane after commit");
    do_read(9, "R3 forward other address");

    do_write(10, 18'h3_0F0F, 2'b11);
    do_read(11, "R5 read other address");
    do_read(12, "R5 read other address");
    idle(2);
    do_read(10, "R5 parked across reads");
    do_write(13, 18'h0_0042, 2'b11);
    do_read(10, "R5 committed by next write");

    do_write(30, 18'h1_2345, 2'b11);
    do_write(31, 18'h2_2222, 2'b11);
    do_write(30, 18'h3_FE00, 2'b10);
    do_read(30, "R6 merge upper from register");
    do_write(31, 18'h0_01FF, 2'b01);
    do_read(31, "R6 merge lower from register");

    do_write(40, 18'h2_AAAA, 2'b11);
    do_write(40, 18'h1_C0DE, 2'b01);
    do_read(40, "R7 same address back to back");
    do_write(41, 18'h0_7777, 2'b10);
    do_read(40, "R7 both commits in array");
    do_read(41, "R7 new parked entry");

    do_write(50, 18'h3_FFFF, 2'b00);
    do_read(50, "R8 no lanes enabled");
    do_read(41, "R8 previous entry committed");
    do_write(51, 18'h1_0001, 2'b11);
    do_read(50, "R8 still unchanged after commit");

    for (int k = 0; k < 20; k++) begin
      do_write(k[AW-1:0] + 6'd20, DW'(k * 999 + 3), 2'(k % 4));
      do_read(k[AW-1:0] + 6'd20, "R6 mixed lane pattern");
    end
    idle(4);
    check("R2 all reads returned", DW'(exp_q.size()), '0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule